// File: doc/BRIEF.md
# Double-Width Unsigned Divider

This unit divides an unsigned dividend of twice the word width by an unsigned divisor of one word. The dividend is built from two input words: `hi_i` forms the upper half and `lo_i` the lower half. The divisor is zero-extended to the width of the dividend. The result is a one-word quotient and a one-word remainder.

One test gates the whole operation: the high word must be unsigned-less-than the divisor. When the test fails, the quotient cannot fit in one word, and this test also catches a divisor of zero. In that case the unit raises `ov_o` and returns all ones in both result words.

A pulse on `start_i` while the unit is idle captures the operands. The unit then works one quotient bit per clock using restoring radix-2 division. After XLEN cycles it raises `done_o` for a single cycle, and the result outputs hold their value from then on. Signed division is not handled.

Top module: `wdiv_top`

## Requirements
- R1: When `hi_i < divisor_i` (unsigned) and `divisor_i != 0`, the delivered quotient equals `{hi_i, lo_i}` divided by `divisor_i`, truncated.
- R2: For a valid division the delivered remainder equals `{hi_i, lo_i}` minus quotient times divisor, and it is less than the divisor.
- R3: When `hi_i >= divisor_i` (unsigned), including `divisor_i == 0`, the delivered `ov_o` is 1 and `quotient_o` and `remainder_o` are all ones.
- R4: For a valid division the delivered `ov_o` is 0.
- R5: A start accepted at clock edge k drives `busy_o` high after edge k, and `done_o` rises after edge k+XLEN. `busy_o` is low in the cycle in which `done_o` is high.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: A `start_i` pulse while `busy_o` is high is ignored: it changes neither the operands in use nor the completion cycle.
- R8: `quotient_o`, `remainder_o` and `ov_o` change only on the edge that raises `done_o`. Between results they hold their value.
- R9: After reset `busy_o`, `done_o` and `ov_o` are 0 and `quotient_o` and `remainder_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; taken only while idle |
| hi_i | input | XLEN | Upper word of the dividend |
| lo_i | input | XLEN | Lower word of the dividend |
| divisor_i | input | XLEN | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | XLEN | Quotient, or all ones on overflow |
| remainder_o | output | XLEN | Remainder, or all ones on overflow |
| ov_o | output | 1 | Quotient would not fit, or divisor is zero |

## Verification
The checker captures the operands at each accepted start. At every completion it checks the overflow gate, the all-ones result on overflow, and the identity that the quotient times the divisor plus the remainder equals the dividend, with the remainder below the divisor. On every cycle it also checks the XLEN-cycle latency, the single-cycle done pulse, and that the outputs hold between results. Some behaviour only the bench scenarios show: the exact quotient over an exhaustive sweep of a 4-bit configuration, that a start issued mid-run leaves the result unchanged, and the reset values.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wdiv_state_e;
endpackage

// File: rtl/wdiv_gate.sv
// Overflow gate: quotient fits in one word only if hi < divisor (covers zero).
module wdiv_gate #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] div_i,
  output logic            ok_o
);
  always_comb ok_o = (div_i != '0) && (hi_i < div_i);
endmodule

// File: rtl/wdiv_step.sv
// One restoring radix-2 step: shift in next dividend bit, subtract if it fits.
module wdiv_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem_i,
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] div_i,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] quo_o
);
  logic [XLEN:0] part;
  logic [XLEN:0] diff;
  logic          ge;

  always_comb begin
    part  = {rem_i, quo_i[XLEN-1]};
    diff  = part - {1'b0, div_i};
    ge    = part >= {1'b0, div_i};
    rem_o = ge ? diff[XLEN-1:0] : part[XLEN-1:0];
    quo_o = {quo_i[XLEN-2:0], ge};
  end
endmodule

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
  import wdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;

  wdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    load_o = start_i && (state_q == ST_IDLE);
    step_o = (state_q == ST_RUN);
    last_o = step_o && (cnt_q == CW'(XLEN - 1));
    busy_o = step_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_o) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdiv_top.sv
module wdiv_top #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] quotient_o,
  output logic [XLEN-1:0] remainder_o,
  output logic            ov_o
);
  logic            load, step, last, ok_in;
  logic            ok_q;
  logic [XLEN-1:0] rem_q, quo_q, div_q;
  logic [XLEN-1:0] rem_n, quo_n;

  wdiv_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .done_o (done_o)
  );

  wdiv_gate #(.XLEN(XLEN)) u_gate (
    .hi_i (hi_i),
    .div_i(divisor_i),
    .ok_o (ok_in)
  );

  wdiv_step #(.XLEN(XLEN)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .div_i(div_q),
    .rem_o(rem_n),
    .quo_o(quo_n)
  );

  // Working registers: remainder seeded with hi, quotient shifter with lo.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      ok_q  <= 1'b0;
    end else if (load) begin
      rem_q <= hi_i;
      quo_q <= lo_i;
      div_q <= divisor_i;
      ok_q  <= ok_in;
    end else if (step) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  // Result registers update only on the final step.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quotient_o  <= '0;
      remainder_o <= '0;
      ov_o        <= 1'b0;
    end else if (last) begin
      quotient_o  <= ok_q ? quo_n : '1;
      remainder_o <= ok_q ? rem_n : '1;
      ov_o        <= !ok_q;
    end
  end
endmodule

// File: rtl/wdiv_chk.sv
module wdiv_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [XLEN-1:0] hi_i,
  input logic [XLEN-1:0] lo_i,
  input logic [XLEN-1:0] divisor_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] quotient_o,
  input logic [XLEN-1:0] remainder_o,
  input logic            ov_o
);
  localparam int LW = $clog2(XLEN + 1) + 1;
  localparam int DW = 2 * XLEN;

  logic [XLEN-1:0] cap_hi, cap_lo, cap_div;
  logic [LW-1:0]   lat_q;
  logic [DW-1:0]   recon, dividend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_hi  <= '0;
      cap_lo  <= '0;
      cap_div <= '0;
      lat_q   <= '0;
    end else if (start_i && !busy_o) begin
      cap_hi  <= hi_i;
      cap_lo  <= lo_i;
      cap_div <= divisor_i;
      lat_q   <= '0;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  always_comb begin
    dividend = {cap_hi, cap_lo};
    recon    = ({{XLEN{1'b0}}, quotient_o} * {{XLEN{1'b0}}, cap_div})
             + {{XLEN{1'b0}}, remainder_o};
  end

  // R1
  identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ov_o) |-> (recon == dividend));
  // R2
  rem_below_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ov_o) |-> (remainder_o < cap_div));
  // R3
  ov_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ov_o) |-> (quotient_o == '1 && remainder_o == '1));
  // R3
  ov_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ov_o == ((cap_div == '0) || (cap_hi >= cap_div))));
  // R5
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LW'(XLEN) && !busy_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(ov_o)));
endmodule

bind wdiv_top wdiv_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .hi_i       (hi_i),
  .lo_i       (lo_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .ov_o       (ov_o)
);

// File: tb/sim_wdiv_top.sv
`timescale 1ns/1ps
module sim_wdiv_top;
  localparam int XLEN = 4;
  localparam int MAXV = 1 << XLEN;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [XLEN-1:0] hi = '0, lo = '0, dv = '0;
  logic            busy, done, ov;
  logic [XLEN-1:0] quo, rem;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  wdiv_top #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .hi_i(hi), .lo_i(lo), .divisor_i(dv),
    .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem), .ov_o(ov)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int h, input int l, input int d, input bit poke);
    int cyc;
    int dd, eq, er;
    bit valid;
    valid = (d != 0) && (h < d);
    dd = h * MAXV + l;
    eq = valid ? dd / d : MAXV - 1;
    er = valid ? dd % d : MAXV - 1;
    @(negedge clk);
    start = 1'b1; hi = XLEN'(h); lo = XLEN'(l); dv = XLEN'(d);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk(busy == 1'b1, "R5", busy, 1);
    while (!done && cyc < 4 * XLEN) begin
      if (poke && cyc == 1) begin
        // R7: foreign start mid-run
        start = 1'b1; hi = ~XLEN'(h); lo = ~XLEN'(l); dv = XLEN'(d + 1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == XLEN, poke ? "R7" : "R5", cyc, XLEN);
    chk(busy == 1'b0, "R5", busy, 0);
    chk(quo == XLEN'(eq), valid ? "R1" : "R3", quo, eq);
    chk(rem == XLEN'(er), valid ? "R2" : "R3", rem, er);
    chk(ov == !valid, valid ? "R4" : "R3", ov, !valid);
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
    chk(quo == XLEN'(eq) && rem == XLEN'(er) && ov == !valid, "R8", quo, eq);
    chk(busy == 1'b0, poke ? "R7" : "R5", busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(busy == 0 && done == 0 && ov == 0, "R9", {busy, done, ov}, 0);
    chk(quo == 0 && rem == 0, "R9", {quo, rem}, 0);
    for (int d = 0; d < MAXV; d++)
      for (int h = 0; h < MAXV; h++)
        for (int l = 0; l < MAXV; l++)
          run_op(h, l, d, ((h + l + d) % 11) == 0);
    // boundaries: largest valid, divisor zero with zero high word
    run_op(MAXV - 2, MAXV - 1, MAXV - 1, 1'b0);
    run_op(0, 0, 0, 1'b1);
    run_op(1, 0, 1, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule